// File: doc/BRIEF.md
# Alternating-Half Access Time Tester

This block is a test sequencer that measures how many wait cycles a synchronous RAM needs between address presentation and valid read data. Each test pass has three steps. It writes all-zero words into the lower half of the array and all-one words into the upper half. It reads the whole array back in ascending order. It then reads addresses in pairs taken alternately from the two halves, so every sample lands just after a full data swing on the read path.

The wait count sets the effective access time. Each read address is held on the port for the programmed number of wait cycles plus one, and read data is sampled in the last of those cycles. The block has two modes. In production mode it runs one pass at the given wait count and reports pass or fail. In characterization mode it starts at the given count and lowers it by one after every fully passing pass, until a pass fails or the count reaches zero. It then reports the smallest count that passed.

The RAM port is a plain synchronous memory port with no handshake. `start`, `char_mode` and the result pins are plain control and status signals; no valid/ready stream crosses the block's edge.

Top module: `ath_tester`

## Requirements
- R1: A pass begins by writing every address once, in ascending order, one write per cycle. Addresses whose top bit is 0 receive all zeros and addresses whose top bit is 1 receive all ones (`mem_we`=1 together with `mem_en`=1).
- R2: After the writes, every address is read in ascending order (0 to N-1). Each sampled word is compared with all zeros (top address bit 0) or all ones (top address bit 1).
- R3: After the ascending read, the alternating read presents address i and then address i+N/2, for i from 0 to N/2-1. The top address bit therefore flips on every address change in this phase.
- R4: Each read address stays on `mem_addr` for exactly W+1 cycles, where W is the current wait count, and `mem_rdata` is sampled in the last of those cycles.
- R5: The first mismatching read ends the pass at once; no further RAM access follows in that pass.
- R6: With `char_mode`=0, exactly one pass runs at `init_wait`. At the end `done`=1, `pass` shows the outcome and `limit_valid`=0.
- R7: With `char_mode`=1, each fully passing pass at W>0 is followed by a new pass at W-1. When a pass fails after at least one full pass, `done`=1, `pass`=1, `limit_valid`=1, and `limit` holds the smallest count that passed.
- R8: In characterization mode, a full pass at W=0 ends the run with `pass`=1, `limit_valid`=1 and `limit`=0.
- R9: In characterization mode, if the pass at `init_wait` fails, the run ends with `pass`=0 and `limit_valid`=0.
- R10: After reset, `done`, `pass`, `limit_valid`, `mem_en` and `mem_we` are 0.
- R11: `start` and `char_mode` are sampled only while idle. A `start` pulse during a run has no effect. The results stay on the outputs until the next accepted `start` clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted while idle) |
| char_mode | input | 1 | 0 = production pass, 1 = downward search |
| init_wait | input | WAIT_W | Starting wait count |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data |
| done | output | 1 | Run finished; results valid |
| pass | output | 1 | Outcome of the run |
| limit | output | WAIT_W | Smallest passing wait count |
| limit_valid | output | 1 | `limit` holds a measured value |

## Verification
The assertions check the following on every cycle:
- a read address holds steady until its sample cycle;
- the wait counter stays within the current count;
- every address step in the alternating phase crosses halves;
- the wait count never rises during a run;
- a reported limit always comes with a pass;
- a production result never claims a limit;
- `done` stays low while a pass is in progress.

Other behaviour can only be shown by the bench scenarios, which drive a RAM model whose read latency is set per scenario:
- the passing threshold found by the downward search;
- the immediate-failure and zero-limit endings;
- the exact write and read order and the hold length of each read;
- the abort after the first mismatch;
- that a `start` during a run is ignored.

// File: rtl/ath_pkg.sv
package ath_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_CHECK,
    ST_ALT,
    ST_EVAL
  } ath_state_e;
endpackage

// File: rtl/ath_addr_seq.sv
module ath_addr_seq #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              phase_alt,
  output logic [ADDR_W-1:0] addr,
  output logic              exp_one,
  output logic              last
);
  localparam int MSB = ADDR_W - 1;

  logic [ADDR_W-1:0] cnt_q;
  logic              hi_q;

  assign addr    = phase_alt ? {hi_q, cnt_q[MSB-1:0]} : cnt_q;
  assign exp_one = addr[MSB];
  assign last    = phase_alt ? (hi_q && (&cnt_q[MSB-1:0])) : (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (step) begin
      if (phase_alt) begin
        if (hi_q) cnt_q <= cnt_q + 1'b1;
        hi_q <= ~hi_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ath_wait_timer.sv
module ath_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WAIT_W-1:0] lim,
  output logic              sample
);
  logic [WAIT_W-1:0] cnt_q;

  assign sample = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || sample) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim));
endmodule

// File: rtl/ath_search.sv
module ath_search #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] init,
  input  logic              record,
  output logic [WAIT_W-1:0] wait_q,
  output logic [WAIT_W-1:0] best_q,
  output logic              ever_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      best_q <= '0;
      ever_q <= 1'b0;
    end else if (load) begin
      wait_q <= init;
      ever_q <= 1'b0;
    end else if (record) begin
      best_q <= wait_q;
      ever_q <= 1'b1;
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
    end
  end

  // R7
  wait_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (wait_q <= $past(wait_q)));
endmodule

// File: rtl/ath_tester.sv
module ath_tester
  import ath_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              char_mode,
  input  logic [WAIT_W-1:0] init_wait,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              pass,
  output logic [WAIT_W-1:0] limit,
  output logic              limit_valid
);
  localparam int MSB = ADDR_W - 1;

  ath_state_e        state_q;
  logic              mode_q, ok_q;
  logic              rd_phase, sample, match;
  logic              seq_clear, seq_step, seq_last, exp_one;
  logic [ADDR_W-1:0] seq_addr;
  logic [WAIT_W-1:0] wait_cur, best;
  logic              ever, srch_load, srch_record;

  assign rd_phase    = (state_q == ST_CHECK) || (state_q == ST_ALT);
  assign match       = (mem_rdata == {DATA_W{exp_one}});
  assign srch_load   = (state_q == ST_IDLE) && start;
  assign srch_record = (state_q == ST_EVAL) && mode_q && ok_q;

  always_comb begin
    seq_clear = (state_q == ST_IDLE) || (state_q == ST_EVAL) ||
                ((state_q == ST_FILL) && seq_last) ||
                ((state_q == ST_CHECK) && sample && match && seq_last);
    seq_step  = (state_q == ST_FILL) || (rd_phase && sample && match);
  end

  ath_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(seq_clear), .step(seq_step),
    .phase_alt(state_q == ST_ALT), .addr(seq_addr), .exp_one(exp_one),
    .last(seq_last)
  );

  ath_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(rd_phase), .lim(wait_cur), .sample(sample)
  );

  ath_search #(.WAIT_W(WAIT_W)) u_search (
    .clk(clk), .rst_n(rst_n), .load(srch_load), .init(init_wait),
    .record(srch_record), .wait_q(wait_cur), .best_q(best), .ever_q(ever)
  );

  assign mem_en    = (state_q == ST_FILL) || rd_phase;
  assign mem_we    = (state_q == ST_FILL);
  assign mem_addr  = seq_addr;
  assign mem_wdata = {DATA_W{exp_one}};
  assign limit     = best;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= 1'b0;
      ok_q        <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      limit_valid <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q     <= ST_FILL;
          mode_q      <= char_mode;
          done        <= 1'b0;
          pass        <= 1'b0;
          limit_valid <= 1'b0;
        end
        ST_FILL: if (seq_last) state_q <= ST_CHECK;
        ST_CHECK: if (sample) begin
          if (!match) begin
            ok_q    <= 1'b0;
            state_q <= ST_EVAL;
          end else if (seq_last) begin
            state_q <= ST_ALT;
          end
        end
        ST_ALT: if (sample) begin
          if (!match) begin
            ok_q    <= 1'b0;
            state_q <= ST_EVAL;
          end else if (seq_last) begin
            ok_q    <= 1'b1;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (!mode_q) begin
            done    <= 1'b1;
            pass    <= ok_q;
            state_q <= ST_IDLE;
          end else if (ok_q && (wait_cur != '0)) begin
            state_q <= ST_FILL;
          end else if (ok_q) begin
            done        <= 1'b1;
            pass        <= 1'b1;
            limit_valid <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            done        <= 1'b1;
            pass        <= ever;
            limit_valid <= ever;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && !sample) |=> $stable(mem_addr));

  // R3
  alt_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ALT) && sample && match && !seq_last)
      |=> (mem_addr[MSB] != $past(mem_addr[MSB])));

  // R7
  limit_implies_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_valid |-> pass);

  // R6
  prod_no_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> !limit_valid);

  // R11
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && (state_q != ST_EVAL)) |-> !done);
endmodule

// File: tb/sim_ath_tester.sv
module sim_ath_tester;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int WW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          char_mode = 1'b0;
  logic [WW-1:0] init_wait = '0;
  logic          mem_en, mem_we, done, pass, limit_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [WW-1:0] limit;

  always #10 clk = ~clk;

  ath_tester #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .char_mode(char_mode),
    .init_wait(init_wait), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .pass(pass), .limit(limit), .limit_valid(limit_valid)
  );

  // RAM model: data is valid once the address has been held for lat+1 cycles;
  // before that the previous word stays on the bus.
  logic [DW-1:0] mem [N];
  logic [AW-1:0] addr_q;
  logic          track_q;
  int            age_q;
  logic [DW-1:0] old_q;
  int            lat;
  bit            fast;

  always_comb begin
    if (fast) mem_rdata = mem[mem_addr];
    else if (track_q && addr_q == mem_addr && age_q >= lat) mem_rdata = mem[addr_q];
    else mem_rdata = old_q;
  end

  always_ff @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    old_q <= (mem_en && mem_we) ? mem_wdata : mem_rdata;
    if (!mem_en || mem_we || mem_addr != addr_q || !track_q) begin
      addr_q  <= mem_addr;
      age_q   <= 0;
      track_q <= mem_en && !mem_we;
    end else begin
      age_q <= age_q + 1;
    end
  end

  int total = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct packed {
    logic          p;
    logic          lv;
    logic [WW-1:0] lim;
  } res_t;
  res_t  exp_q[$];
  string tag_q[$];

  logic done_d = 1'b0;
  always @(negedge clk) begin
    if (done && !done_d && exp_q.size() > 0) begin
      res_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(pass == e.p, {t, " pass"}, pass, e.p);
      check(limit_valid == e.lv, {t, " limit_valid"}, limit_valid, e.lv);
      if (e.lv) check(limit == e.lim, {t, " limit"}, limit, e.lim);
    end
    done_d = done;
  end

  // access monitor
  int wr_cnt, wr_order_err, rd_cnt, flips, run_len, min_run, max_run;
  bit in_run, have_prev, prev_msb;
  logic [AW-1:0] cur_addr;
  int rd_seq [64];

  task automatic clear_stats();
    wr_cnt = 0; wr_order_err = 0; rd_cnt = 0; flips = 0; run_len = 0;
    min_run = 1000; max_run = 0; in_run = 0; have_prev = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_en && !mem_we) begin
      if (in_run && mem_addr == cur_addr) begin
        run_len++;
      end else begin
        if (in_run) begin
          if (run_len < min_run) min_run = run_len;
          if (run_len > max_run) max_run = run_len;
        end
        if (rd_cnt < 64) rd_seq[rd_cnt] = int'(mem_addr);
        rd_cnt++;
        if (have_prev && mem_addr[AW-1] != prev_msb) flips++;
        prev_msb = mem_addr[AW-1]; have_prev = 1;
        cur_addr = mem_addr; run_len = 1; in_run = 1;
      end
    end else begin
      if (in_run) begin
        if (run_len < min_run) min_run = run_len;
        if (run_len > max_run) max_run = run_len;
      end
      in_run = 0;
      if (rst_n && mem_en && mem_we) begin
        if (mem_addr != AW'(wr_cnt)) wr_order_err++;
        wr_cnt++;
      end
    end
  end

  task automatic run(input bit cm, input int w, input int l, input bit f,
                     input string t, input bit ep, input bit elv, input int elim,
                     input bit poke);
    res_t e;
    lat = l; fast = f;
    clear_stats();
    e.p = ep; e.lv = elv; e.lim = WW'(elim);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); char_mode = cm; init_wait = WW'(w); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (25) @(negedge clk);
      char_mode = ~cm; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    lat = 2; fast = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!done && !pass && !limit_valid, "R10 status", {done, pass, limit_valid}, 0);
    check(!mem_en && !mem_we, "R10 ram idle", {mem_en, mem_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 production pass at W=5, latency 2 (needs W>=3); R11 start poke ignored
    run(1'b0, 5, 2, 1'b0, "R6/R11 prod W5", 1'b1, 1'b0, 0, 1'b1);
    check(wr_cnt == N && wr_order_err == 0, "R1 write order", wr_cnt, N);
    begin
      bit ok = 1;
      for (int i = 0; i < N; i++)
        if (mem[i] != ((i >= N/2) ? {DW{1'b1}} : '0)) ok = 0;
      check(ok, "R1 array contents", ok, 1);
    end
    check(rd_cnt == 2*N, "R11 single pass reads", rd_cnt, 2*N);
    begin
      bit ok = 1;
      for (int i = 0; i < N; i++) if (rd_seq[i] != i) ok = 0;
      check(ok, "R2 ascending read", ok, 1);
      ok = 1;
      for (int k = 0; k < N; k++)
        if (rd_seq[N+k] != ((k % 2) ? N/2 : 0) + k/2) ok = 0;
      check(ok, "R3 alternate order", ok, 1);
    end
    check(flips == N + 1, "R3 half crossings", flips, N + 1);
    check(min_run == 6 && max_run == 6, "R4 hold W+1", min_run, 6);
    check(done && !limit_valid, "R11 result held", {done, limit_valid}, 2);

    // R6 boundary: W=3 passes, W=2 fails
    run(1'b0, 3, 2, 1'b0, "R6 prod W3", 1'b1, 1'b0, 0, 1'b0);
    check(min_run == 4 && max_run == 4, "R4 hold W3", max_run, 4);
    run(1'b0, 2, 2, 1'b0, "R6 prod W2", 1'b0, 1'b0, 0, 1'b0);
    check(rd_cnt == 1, "R5 abort on first mismatch", rd_cnt, 1);

    // R7 search downward
    run(1'b1, 6, 2, 1'b0, "R7 char W6", 1'b1, 1'b1, 3, 1'b0);
    run(1'b1, 3, 2, 1'b0, "R7 char W3", 1'b1, 1'b1, 3, 1'b0);
    run(1'b1, 4, 0, 1'b0, "R7 char lat0", 1'b1, 1'b1, 1, 1'b0);
    // R9 immediate failure
    run(1'b1, 2, 2, 1'b0, "R9 char W2", 1'b0, 1'b0, 0, 1'b0);
    // R8 reaches zero
    run(1'b1, 4, 0, 1'b1, "R8 char fast", 1'b1, 1'b1, 0, 1'b0);
    run(1'b0, 0, 0, 1'b1, "R6 prod fast W0", 1'b1, 1'b0, 0, 1'b0);
    check(min_run == 1 && max_run == 1, "R4 hold W0", max_run, 1);

    check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule